// File: doc/BRIEF.md
# Half-Band 2x Interpolating DAC Output Filter

This block sits at the end of a video encoder and turns a 12-bit signed sample stream into the 12-bit code that feeds a DAC. With oversampling enabled, every input sample yields two output codes on a single fast clock. One code is a filtered midpoint and the other is a delayed copy of an input sample. Together they form the output of a 27-tap symmetric half-band interpolator. Its odd taps are zero and its centre tap is unity, so only seven shared even-tap coefficients are programmable.

With oversampling disabled, accepted samples go straight to the output register. A final stage can invert the code bit by bit, and it forces zero when the output-select field names a reserved source.

The input is a valid/ready stream. A sample transfers on a clock edge where `in_valid` and `in_ready` are both high, and the source must hold `in_data` steady until that edge. In oversampling mode `in_ready` is high on every second cycle, which is the input slot. If no sample is offered in a slot, the filter takes a zero sample there and keeps its cadence. In bypass mode `in_ready` is always high. The coefficient write port and the mode pins are plain control inputs. Mode changes are meant to happen while the stream is idle.

Top module: `hbi_dac_interp`

## Requirements
- R1: After reset `dac_code` is 0 and the seven coefficients c0..c6 hold 0, 0, 0, 0, 6, -20, 78. These are signed 9-bit values with 7 fraction bits.
- R2: With `os_en` low, `in_ready` is always 1. With `os_en` high, `in_ready` is 1 in the first cycle after `os_en` rises and then alternates every cycle.
- R3: With `os_en` low, a transferred sample appears as the output value one cycle after its transfer edge. Without a transfer the output value holds.
- R4: With `os_en` high, the input slot edge that takes sample x[n] is followed by two outputs in order. On the next edge the output becomes the filtered value y[2n]. On the edge after that it becomes x[n-6]. Each becomes visible in the cycle after its edge.
- R5: The filtered value is y[2n] = sum over j of cj·(x[n-j]+x[n-13+j]), for j = 0..6. The sum is kept at full precision, then divided by 128 with round-half-up (add 64, arithmetic shift right by 7), then saturated to [-2048, 2047].
- R6: An oversampling input slot with `in_valid` low enters a zero sample into the filter history.
- R7: A cycle with `coef_we` high and `coef_addr` in 0..6 writes `coef_wdata` into that coefficient from the next cycle on. Address 7 changes nothing.
- R8: With `out_sel` = 0 and `invert` high, `dac_code` is the bitwise NOT of the output value. With `invert` low it is the output value.
- R9: With `out_sel` nonzero (reserved sources 1..15), `dac_code` is 0. Value 0 selects the composite video path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast (DAC) clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block takes a sample this cycle |
| in_data | input | 12 | Signed input sample |
| os_en | input | 1 | 1 = 2x oversampling, 0 = bypass |
| invert | input | 1 | Invert final code bitwise |
| out_sel | input | 4 | Output source select; 0 = composite video |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | 3 | Coefficient index 0..6 |
| coef_wdata | input | 9 | Signed coefficient, 7 fraction bits |
| dac_code | output | 12 | DAC code |

## Verification
The bench builds the block with its default parameters: 12-bit samples, 9-bit coefficients with 7 fraction bits, and seven coefficient pairs. This reaches the full 27-tap window, so the `x[n-6]` centre tap and the `x[n-13]` mirror are both exercised. With 9-bit coefficients set to their largest values and full-scale inputs, the sum overflows past both 12-bit bounds, so saturation at 2047 and -2048 is reachable. Small coefficients and small inputs reach the exact-half rounding case.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
  // Reset value of coefficient idx in a bank of n even-tap coefficients.
  // The three innermost coefficients carry the default half-band shape.
  function automatic int hbi_coef_default(int idx, int n);
    if (idx == n - 1) return 78;
    if (idx == n - 2) return -20;
    if (idx == n - 3) return 6;
    return 0;
  endfunction
endpackage

// File: rtl/hbi_coef_bank.sv
module hbi_coef_bank #(
  parameter int NCOEF = 7,
  parameter int CW    = 9,
  localparam int AW   = $clog2(NCOEF)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [AW-1:0]              addr,
  input  logic [CW-1:0]              wdata,
  output logic [NCOEF-1:0][CW-1:0]   coef
);
  import hbi_pkg::*;

  for (genvar i = 0; i < NCOEF; i++) begin : g_reg
    localparam logic [CW-1:0] RST = CW'(hbi_coef_default(i, NCOEF));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) coef[i] <= RST;
      else if (we && addr == AW'(i)) coef[i] <= wdata;
    end
  end
endmodule

// File: rtl/hbi_window.sv
module hbi_window #(
  parameter int DW    = 12,
  parameter int DEPTH = 14
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      shift,
  input  logic [DW-1:0]             din,
  output logic [DEPTH-1:0][DW-1:0]  taps
);
  // taps[0] is the newest sample, taps[DEPTH-1] the oldest.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) taps[0] <= '0;
    else if (shift) taps[0] <= din;
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) taps[i] <= '0;
      else if (shift) taps[i] <= taps[i-1];
    end
  end
endmodule

// File: rtl/hbi_mac.sv
module hbi_mac #(
  parameter int DW    = 12,
  parameter int CW    = 9,
  parameter int FRAC  = 7,
  parameter int NCOEF = 7,
  localparam int DEPTH = 2 * NCOEF
) (
  input  logic [DEPTH-1:0][DW-1:0]  taps,
  input  logic [NCOEF-1:0][CW-1:0]  coef,
  output logic [DW-1:0]             y
);
  localparam int PW    = DW + 1;
  localparam int PRODW = PW + CW;
  localparam int ACCW  = PRODW + $clog2(NCOEF) + 1;
  localparam logic signed [ACCW-1:0] MAXV = ACCW'((1 << (DW - 1)) - 1);
  localparam logic signed [ACCW-1:0] MINV = ACCW'(-(1 << (DW - 1)));
  localparam logic signed [ACCW-1:0] HALF = ACCW'(1 << (FRAC - 1));

  logic signed [PW-1:0]    pair [NCOEF];
  logic signed [PRODW-1:0] prod [NCOEF];
  logic signed [ACCW-1:0]  acc, rnd, shifted;

  // Mirror taps share a coefficient: add them before multiplying.
  for (genvar j = 0; j < NCOEF; j++) begin : g_pair
    assign pair[j] = PW'($signed(taps[j])) + PW'($signed(taps[DEPTH-1-j]));
    assign prod[j] = PRODW'(pair[j]) * PRODW'($signed(coef[j]));
  end

  always_comb begin
    acc = '0;
    for (int j = 0; j < NCOEF; j++) acc = acc + ACCW'(prod[j]);
  end

  assign rnd     = acc + HALF;
  assign shifted = rnd >>> FRAC;

  always_comb begin
    if (shifted > MAXV)      y = MAXV[DW-1:0];
    else if (shifted < MINV) y = MINV[DW-1:0];
    else                     y = shifted[DW-1:0];
  end
endmodule

// File: rtl/hbi_dac_interp.sv
module hbi_dac_interp #(
  parameter int DW    = 12,
  parameter int CW    = 9,
  parameter int FRAC  = 7,
  parameter int NCOEF = 7,
  parameter int SW    = 4,
  localparam int AW    = $clog2(NCOEF),
  localparam int DEPTH = 2 * NCOEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          os_en,
  input  logic          invert,
  input  logic [SW-1:0] out_sel,
  input  logic          coef_we,
  input  logic [AW-1:0] coef_addr,
  input  logic [CW-1:0] coef_wdata,
  output logic [DW-1:0] dac_code
);
  logic                      phase;   // 0 = input slot / centre phase, 1 = filtered phase
  logic                      slot;
  logic [DW-1:0]             din;
  logic [DEPTH-1:0][DW-1:0]  taps;
  logic [NCOEF-1:0][CW-1:0]  coef;
  logic [DW-1:0]             filt_y;
  logic [DW-1:0]             out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      phase <= 1'b0;
    else if (!os_en) phase <= 1'b0;
    else             phase <= ~phase;
  end

  assign in_ready = !os_en || !phase;
  assign slot     = os_en && !phase;
  assign din      = in_valid ? in_data : '0;   // an empty slot enters a zero

  hbi_coef_bank #(.NCOEF(NCOEF), .CW(CW)) u_coef (
    .clk(clk), .rst_n(rst_n), .we(coef_we), .addr(coef_addr),
    .wdata(coef_wdata), .coef(coef)
  );

  hbi_window #(.DW(DW), .DEPTH(DEPTH)) u_win (
    .clk(clk), .rst_n(rst_n), .shift(slot), .din(din), .taps(taps)
  );

  hbi_mac #(.DW(DW), .CW(CW), .FRAC(FRAC), .NCOEF(NCOEF)) u_mac (
    .taps(taps), .coef(coef), .y(filt_y)
  );

  // On the slot edge the centre tap is read before the window shifts,
  // so it is the odd-phase output of the previous input sample.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        out_q <= '0;
    else if (os_en)    out_q <= phase ? filt_y : taps[NCOEF-1];
    else if (in_valid) out_q <= in_data;
  end

  always_comb begin
    if (out_sel != '0) dac_code = '0;
    else if (invert)   dac_code = ~out_q;
    else               dac_code = out_q;
  end
endmodule

// File: rtl/hbi_dac_interp_chk.sv
module hbi_dac_interp_chk #(
  parameter int DW = 12,
  parameter int SW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [DW-1:0] in_data,
  input logic          os_en,
  input logic          invert,
  input logic [SW-1:0] out_sel,
  input logic [DW-1:0] dac_code
);
  AST_READY_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    !os_en |-> in_ready); // R2

  AST_READY_TOGGLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (os_en && in_ready) |=> (!os_en || !in_ready)); // R2

  AST_READY_TOGGLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (os_en && !in_ready) |=> in_ready); // R2

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sel != '0) |-> (dac_code == '0)); // R9

  AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (!os_en && in_valid) |=>
      (out_sel != '0 || dac_code == (invert ? ~$past(in_data) : $past(in_data)))); // R3
endmodule

bind hbi_dac_interp hbi_dac_interp_chk #(.DW(DW), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_data(in_data), .os_en(os_en), .invert(invert), .out_sel(out_sel),
  .dac_code(dac_code)
);

// File: tb/hbi_dac_interp_test.sv
module hbi_dac_interp_test;
  localparam int PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0;
  logic        in_ready;
  logic [11:0] in_data = '0;
  logic        os_en = 0;
  logic        invert = 0;
  logic [3:0]  out_sel = '0;
  logic        coef_we = 0;
  logic [2:0]  coef_addr = '0;
  logic [8:0]  coef_wdata = '0;
  logic [11:0] dac_code;

  int checks = 0, fails = 0, cyc = 0;
  string cur_req = "R1";
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  hbi_dac_interp uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .os_en(os_en), .invert(invert), .out_sel(out_sel),
    .coef_we(coef_we), .coef_addr(coef_addr), .coef_wdata(coef_wdata),
    .dac_code(dac_code)
  );

  // ---------------- behavioural reference ----------------
  int m_hist[$];   // newest first, always 14 entries
  int m_c[7];
  int m_out;
  bit m_ph;

  function automatic int sx(logic [11:0] v); return int'($signed(v)); endfunction

  function automatic int m_filter();
    longint acc = 0;
    int r;
    for (int j = 0; j < 7; j++) acc += longint'(m_c[j]) * (m_hist[j] + m_hist[13-j]);
    r = int'((acc + 64) >>> 7);
    if (r > 2047) r = 2047;
    if (r < -2048) r = -2048;
    return r;
  endfunction

  task automatic m_reset();
    m_hist = {};
    for (int i = 0; i < 14; i++) m_hist.push_back(0);
    m_c = '{0, 0, 0, 0, 6, -20, 78};
    m_out = 0;
    m_ph = 0;
  endtask

  initial m_reset();

  always @(posedge clk) begin
    if (!rst_n) m_reset();
    else begin
      int nout = m_out;
      if (os_en) begin
        if (!m_ph) begin
          nout = m_hist[6];
          void'(m_hist.pop_back());
          m_hist.push_front(in_valid ? sx(in_data) : 0);
        end else nout = m_filter();
        m_ph = !m_ph;
      end else begin
        m_ph = 0;
        if (in_valid) nout = sx(in_data);
      end
      if (coef_we && coef_addr < 7) m_c[coef_addr] = int'($signed(coef_wdata));
      m_out = nout;
    end
  end

  function automatic logic [11:0] m_code();
    logic [11:0] v = 12'(m_out);
    if (out_sel != 0) return '0;
    return invert ? ~v : v;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  // compare on every clock, shortly after the edge
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      check(cur_req, "dac_code", int'(dac_code), int'(m_code()));
      check("R2", "in_ready", int'(in_ready), os_en ? int'(!m_ph) : 1);
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 50000);
      summary();
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic send(int d);
    @(negedge clk);
    in_valid = 1; in_data = 12'(d);
    while (!in_ready) @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); in_valid = 0; end
  endtask

  task automatic wcoef(int a, int v);
    @(negedge clk); in_valid = 0;
    coef_we = 1; coef_addr = 3'(a); coef_wdata = 9'(v);
    @(negedge clk); coef_we = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "reset dac_code", int'(dac_code), 0);
    rst_n = 1;
    @(negedge clk);
    check("R1", "dac_code after reset", int'(dac_code), 0);

    cur_req = "R3";                                   // bypass with gaps
    for (int i = 0; i < 20; i++) begin
      send((i * 397 + 11) % 4096);
      if (i % 3 == 0) idle(2);
    end
    idle(3);

    cur_req = "R1";                                   // default coefficients, impulse
    @(negedge clk); os_en = 1;
    send(1024);
    for (int i = 0; i < 16; i++) send(0);

    cur_req = "R4";                                   // random-ish stream
    for (int i = 0; i < 60; i++) send(((i * 1231 + 77) % 4096) - 2048);

    cur_req = "R6";                                   // missed slots enter zeros
    for (int i = 0; i < 10; i++) begin
      send(900 - i * 150);
      idle(3);
    end

    cur_req = "R5";                                   // rounding with tiny gains
    @(negedge clk); in_valid = 0; os_en = 0;
    wcoef(4, 0); wcoef(5, 0); wcoef(6, 1);
    @(negedge clk); os_en = 1;
    for (int i = 0; i < 20; i++) send(64 + (i % 3));
    for (int i = 0; i < 20; i++) send(-64 - (i % 3));

    cur_req = "R7";                                   // write all coefficients, address 7 ignored
    for (int a = 0; a < 7; a++) wcoef(a, 255);
    wcoef(7, 0);
    for (int i = 0; i < 20; i++) send(2047);
    for (int i = 0; i < 20; i++) send(-2048);
    wcoef(6, -256);
    for (int i = 0; i < 20; i++) send(i * 37);

    cur_req = "R8";                                   // inversion
    wcoef(0, 0); wcoef(1, 0); wcoef(2, 0); wcoef(3, 0);
    wcoef(4, 6); wcoef(5, -20); wcoef(6, 78);
    @(negedge clk); invert = 1;
    for (int i = 0; i < 20; i++) send(i * 101 - 900);

    cur_req = "R9";                                   // reserved selects
    for (int s = 1; s < 16; s++) begin
      @(negedge clk); out_sel = 4'(s);
      send(s * 55);
    end
    @(negedge clk); out_sel = 0; invert = 0;
    cur_req = "R3";
    @(negedge clk); in_valid = 0; os_en = 0;
    for (int i = 0; i < 8; i++) send(i * 500);
    idle(4);

    done = 1;
    summary();
    $finish;
  end
endmodule